// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps recently used page translations so that a logical page number can be turned into a physical page number without walking the page tables. It holds 64 entries, arranged as 16 sets of 4 ways. A lookup presents a logical page number and a privilege bit. One cycle later the block returns hit or miss, the physical page number and the write-protect bit that was stored with the entry. After a miss, the surrounding logic fetches the translation and writes it back through the fill port. The block itself picks the way that the fill goes into.

The way is chosen as follows. A way that already holds the same page is reused. If there is no such way, the lowest-numbered invalid way of the set is taken. If every way in the set is valid, the victim is the way named by a global 2-bit counter. This counter advances on every lookup, whether it hits or misses, and its value is captured as the victim at each miss. The flush input invalidates the whole cache in one cycle. A mode input selects 4 KB or 8 KB pages, which moves the index and tag fields within the page number. The mode is meant to change only together with a flush.

Top module: `xlat_cache`

## Requirements
- R1: A lookup accepted with `lk_valid` high produces `rsp_valid` high exactly one cycle later, together with `rsp_hit`, `rsp_ppn` and `rsp_wp`. `rsp_valid` is low in every other cycle.
- R2: A lookup hits only when an entry of the indexed set is valid, has an equal tag and has an equal privilege bit. A hit returns that entry's stored physical page and write-protect bit. A miss returns `rsp_ppn` = 0 and `rsp_wp` = 0.
- R3: When a fill finds no matching entry and the set still has an invalid way, the fill writes the lowest-numbered invalid way. No valid entry is evicted in that case.
- R4: A 2-bit replacement counter resets to 0 and advances by one, wrapping modulo 4, on every cycle with `lk_valid` high, whether the lookup hits or misses. Fills and flushes leave it unchanged.
- R5: On a lookup miss, the value the counter held in that cycle (before it advances) is saved as the victim way. A later fill into a set whose four ways are all valid, with no matching entry, overwrites the saved victim way.
- R6: With `pg_large` = 0 (4 KB pages), the set index is vpn[3:0] and the tag is vpn[19:4]. With `pg_large` = 1 (8 KB pages), the index is vpn[4:1], the tag is vpn[19:5], and a hit returns the stored physical page with bit 0 replaced by bit 0 of the looked-up vpn.
- R7: `flush` invalidates all 64 entries at the next clock edge. It does not change the counter or the saved victim. A fill in the same cycle as a flush is discarded.
- R8: When a fill and a lookup occur in the same cycle, the lookup is answered from the contents before the fill.
- R9: A fill whose page (same set, tag and privilege bit) is already present overwrites that way instead of taking a second way.
- R10: After reset, all entries are invalid, the counter and the saved victim are 0, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_large | input | 1 | Page size: 0 selects 4 KB, 1 selects 8 KB |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Logical page number (address bits 31:12) |
| lk_super | input | 1 | Privilege of the lookup: 1 for supervisor |
| fill_valid | input | 1 | Fill request strobe |
| fill_vpn | input | 20 | Logical page number to install |
| fill_super | input | 1 | Privilege bit to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_wp | input | 1 | Write-protect bit to install |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 20 | Physical page number on a hit, 0 on a miss |
| rsp_wp | output | 1 | Write-protect bit on a hit, 0 on a miss |

## Verification
Three functions can fall in the same cycle. A lookup and a fill can arrive together, and a flush can arrive together with a fill or a lookup. The bench drives a lookup of the very page being filled in that same cycle and expects a miss, then expects a hit on the next lookup. It also sends a flush together with a fill and expects the filled page to miss afterwards. Every response is compared with a reference model kept in the bench. That model tracks the counter across hits, misses and flushes, so any eviction that differs from the required victim order shows up as a wrong hit or miss on a later probe.

// File: rtl/tc_pkg.sv
// Shared definitions for the translation cache.
// Assumes: page size changes only together with a flush.
package tc_pkg;
    typedef enum logic {
        PG_SMALL = 1'b0,
        PG_LARGE = 1'b1
    } pgsz_e;
endpackage

// File: rtl/tc_index.sv
// Splits a logical page number into set index and tag for the current page size.
// Assumes VPN_W > IDX_W + 1; the tag is zero-extended in large-page mode.
module tc_index
    import tc_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int IDX_W = 4,
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic [VPN_W-1:0] vpn,
    input  pgsz_e            pgsz,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // Select index and tag fields by page size.
    always_comb begin
        if (pgsz == PG_LARGE) begin
            idx = vpn[IDX_W:1];
            tag = {1'b0, vpn[VPN_W-1:IDX_W+1]};
        end else begin
            idx = vpn[IDX_W-1:0];
            tag = vpn[VPN_W-1:IDX_W];
        end
    end
endmodule

// File: rtl/tc_repl.sv
// Replacement logic: a free-running access counter, the victim captured at a miss,
// and the way selection for a fill (match, then lowest invalid, then victim).
// Assumes lk_miss is meaningful only while lk_valid is high.
module tc_repl #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_miss,
    input  logic             fill_en,
    input  logic [WAYS-1:0]  set_vld,
    input  logic [WAYS-1:0]  set_match,
    output logic [WAY_W-1:0] fill_way
);
    logic [WAY_W-1:0] ctr_q;
    logic [WAY_W-1:0] victim_q;

    // Counter advances on each lookup; a miss captures the pre-advance value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q    <= '0;
            victim_q <= '0;
        end else if (lk_valid) begin
            ctr_q <= ctr_q + 1'b1;
            if (lk_miss) begin
                victim_q <= ctr_q;
            end
        end
    end

    // Choose the fill way: matching way, else lowest invalid, else the victim.
    always_comb begin
        fill_way = victim_q;
        if (|set_match) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (set_match[w]) fill_way = WAY_W'(w);
            end
        end else if (!(&set_vld)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!set_vld[w]) fill_way = WAY_W'(w);
            end
        end
    end

    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ctr_q == WAY_W'($past(ctr_q) + 1'b1));
    p_ctr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> $stable(ctr_q));
    p_victim_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_miss) |=> victim_q == $past(ctr_q));
    p_fill_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&set_vld) && !(|set_match)) |-> !set_vld[fill_way]);
endmodule

// File: rtl/tc_store.sv
// Entry storage with per-entry valid bits, parallel tag compare for lookups and
// set status for fills. Reads see contents from before any same-cycle write.
// Assumes at most one way of a set matches (guaranteed by match-first fill).
module tc_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int PPN_W = 20,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int ENTS  = SETS * WAYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_super,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wp,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_super,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wp,
    output logic [WAYS-1:0]  set_vld,
    output logic [WAYS-1:0]  set_match
);
    logic [ENTS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q   [ENTS];
    logic             super_q [ENTS];
    logic [PPN_W-1:0] ppn_q   [ENTS];
    logic             wp_q    [ENTS];
    logic [WAYS-1:0]  hit_vec;

    // Valid bits: cleared by reset or flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[{fill_idx, fill_way}] <= 1'b1;
        end
    end

    // Entry payload written on a fill; no reset needed behind valid bits.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[{fill_idx, fill_way}]   <= fill_tag;
            super_q[{fill_idx, fill_way}] <= fill_super;
            ppn_q[{fill_idx, fill_way}]   <= fill_ppn;
            wp_q[{fill_idx, fill_way}]    <= fill_wp;
        end
    end

    // Per-way compare for the lookup set and the fill set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WSEL = WAY_W'(w);
        assign hit_vec[w]   = vld_q[{lk_idx, WSEL}] && (tag_q[{lk_idx, WSEL}] == lk_tag)
                              && (super_q[{lk_idx, WSEL}] == lk_super);
        assign set_vld[w]   = vld_q[{fill_idx, WSEL}];
        assign set_match[w] = vld_q[{fill_idx, WSEL}] && (tag_q[{fill_idx, WSEL}] == fill_tag)
                              && (super_q[{fill_idx, WSEL}] == fill_super);
    end

    // Gather the hitting way's payload by OR over the one-hot hit vector.
    always_comb begin
        lk_hit = |hit_vec;
        lk_ppn = '0;
        lk_wp  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                lk_ppn = lk_ppn | ppn_q[{lk_idx, WAY_W'(w)}];
                lk_wp  = lk_wp | wp_q[{lk_idx, WAY_W'(w)}];
            end
        end
    end

    p_hit_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));
    p_fill_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> vld_q[{$past(fill_idx), $past(fill_way)}]);
endmodule

// File: rtl/xlat_cache.sv
// Top of the set-associative translation cache: index split, storage, replacement
// and a registered lookup response one cycle after the request.
// Assumes pg_large changes only with a flush; fill is dropped when flush is high.
module xlat_cache
    import tc_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_large,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_super,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_super,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wp,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_wp
);
    pgsz_e            pgsz;
    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    logic             lk_hit, lk_wp, fill_en;
    logic [PPN_W-1:0] lk_ppn;
    logic [WAY_W-1:0] fill_way;
    logic [WAYS-1:0]  set_vld, set_match;

    assign pgsz    = pgsz_e'(pg_large);
    assign fill_en = fill_valid && !flush;

    tc_index #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_index (
        .vpn(lk_vpn), .pgsz(pgsz), .idx(lk_idx), .tag(lk_tag));

    tc_index #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_index (
        .vpn(fill_vpn), .pgsz(pgsz), .idx(fill_idx), .tag(fill_tag));

    tc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_super(lk_super),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_wp(lk_wp),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_super(fill_super), .fill_ppn(fill_ppn),
        .fill_wp(fill_wp), .set_vld(set_vld), .set_match(set_match));

    tc_repl #(.WAYS(WAYS)) u_repl (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_miss(!lk_hit),
        .fill_en(fill_en), .set_vld(set_vld), .set_match(set_match),
        .fill_way(fill_way));

    // Register the lookup result; large pages pass vpn bit 0 through to the ppn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_wp    <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_wp    <= lk_valid && lk_hit && lk_wp;
            if (lk_valid && lk_hit) begin
                rsp_ppn <= (pgsz == PG_LARGE) ? {lk_ppn[PPN_W-1:1], lk_vpn[0]} : lk_ppn;
            end else begin
                rsp_ppn <= '0;
            end
        end
    end

    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(lk_valid));
    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && !rsp_wp));
    p_hit_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_large = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_super = 1'b0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic        fill_super = 1'b0;
    logic [19:0] fill_ppn = '0;
    logic        fill_wp = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_wp;
    logic [19:0] rsp_ppn;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    logic        m_v   [64];
    logic [15:0] m_t   [64];
    logic        m_s   [64];
    logic [19:0] m_p   [64];
    logic        m_w   [64];
    logic [1:0]  m_ctr;
    logic [1:0]  m_vic;
    logic        last_hit;

    always #5 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .pg_large(pg_large),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_super(lk_super),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_super(fill_super),
        .fill_ppn(fill_ppn), .fill_wp(fill_wp), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_wp(rsp_wp));

    // op: 0 lookup, 1 fill ; {op, vpn, super, ppn, wp, exp_hit}
    localparam logic [44:0] TBL [9] = '{
        {2'd0, 20'h00012, 1'b0, 20'h00000, 1'b0, 1'b0},
        {2'd1, 20'h00012, 1'b0, 20'hABCDE, 1'b1, 1'b0},
        {2'd0, 20'h00012, 1'b0, 20'hABCDE, 1'b1, 1'b1},
        {2'd0, 20'h00012, 1'b1, 20'h00000, 1'b0, 1'b0},
        {2'd1, 20'h00023, 1'b1, 20'h11111, 1'b0, 1'b0},
        {2'd0, 20'h00023, 1'b1, 20'h11111, 1'b0, 1'b1},
        {2'd0, 20'h00013, 1'b0, 20'h00000, 1'b0, 1'b0},
        {2'd0, 20'h10012, 1'b0, 20'h00000, 1'b0, 1'b0},
        {2'd0, 20'h00012, 1'b0, 20'hABCDE, 1'b1, 1'b1}
    };

    function automatic int unsigned midx(input logic [19:0] v);
        return pg_large ? int'(v[4:1]) : int'(v[3:0]);
    endfunction

    function automatic logic [15:0] mtag(input logic [19:0] v);
        return pg_large ? {1'b0, v[19:5]} : v[19:4];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        m_ctr = 2'd0;
        m_vic = 2'd0;
    endtask

    // one clock cycle with any combination of lookup, fill and flush
    task automatic cyc(input logic lk, input logic [19:0] lv, input logic ls,
                       input logic fv, input logic [19:0] fvp, input logic fs,
                       input logic [19:0] fpp, input logic fw, input logic fl,
                       input string req);
        logic eh, ewp;
        logic [19:0] epp;
        int unsigned b, way;
        bit found;
        eh = 1'b0; epp = '0; ewp = 1'b0;
        b = midx(lv) * 4;
        for (int w = 0; w < 4; w++) begin
            if (m_v[b+w] && m_t[b+w] == mtag(lv) && m_s[b+w] == ls) begin
                eh = 1'b1;
                epp = pg_large ? {m_p[b+w][19:1], lv[0]} : m_p[b+w];
                ewp = m_w[b+w];
            end
        end
        @(negedge clk);
        lk_valid = lk; lk_vpn = lv; lk_super = ls;
        fill_valid = fv; fill_vpn = fvp; fill_super = fs; fill_ppn = fpp; fill_wp = fw;
        flush = fl;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'(lk));
        if (lk) begin
            check({req, " hit"}, 32'(rsp_hit), 32'(eh));
            check({req, " ppn"}, 32'(rsp_ppn), 32'(epp));
            check({req, " wp"}, 32'(rsp_wp), 32'(ewp));
        end
        last_hit = rsp_hit;
        // model update: flush over fill, fill uses old victim
        if (fl) begin
            for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        end else if (fv) begin
            b = midx(fvp) * 4;
            found = 0;
            way = m_vic;
            for (int w = 0; w < 4; w++)
                if (!found && m_v[b+w] && m_t[b+w] == mtag(fvp) && m_s[b+w] == fs) begin
                    way = w; found = 1;
                end
            for (int w = 0; w < 4; w++)
                if (!found && !m_v[b+w]) begin
                    way = w; found = 1;
                end
            m_v[b+way] = 1'b1; m_t[b+way] = mtag(fvp); m_s[b+way] = fs;
            m_p[b+way] = fpp; m_w[b+way] = fw;
        end
        if (lk) begin
            if (!eh) m_vic = m_ctr;
            m_ctr = m_ctr + 2'd1;
        end
    endtask

    task automatic look(input logic [19:0] v, input logic s, input string req);
        cyc(1'b1, v, s, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, req);
    endtask

    task automatic fill(input logic [19:0] v, input logic s, input logic [19:0] p,
                        input logic w, input string req);
        cyc(1'b0, '0, 1'b0, 1'b1, v, s, p, w, 1'b0, req);
    endtask

    task automatic do_flush(input string req);
        cyc(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, req);
    endtask

    // watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: outputs idle under and just after reset
        check("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);

        // R1 R2: table of basic hit/miss vectors, 4 KB pages
        for (int i = 0; i < 9; i++) begin
            logic [44:0] e;
            e = TBL[i];
            if (e[44:43] == 2'd0) begin
                look(e[42:23], e[22], "R2 table");
                check("R2 table expected hit", 32'(last_hit), 32'(e[0]));
            end else begin
                fill(e[42:23], e[22], e[21:2], e[1], "R1 table fill");
            end
        end

        // R3: invalid-first fill with counter pointing at an occupied way
        do_flush("R7 flush");
        fill(20'h00017, 1'b0, 20'h00100, 1'b0, "R3 fill");
        fill(20'h00027, 1'b0, 20'h00200, 1'b0, "R3 fill");
        while (m_ctr != 2'd0) look(20'h00017, 1'b0, "R4 spin");
        look(20'h00F07, 1'b0, "R5 miss");
        fill(20'h00037, 1'b0, 20'h00300, 1'b0, "R3 fill third");
        look(20'h00017, 1'b0, "R3 way0 kept");
        look(20'h00027, 1'b0, "R3 way1 kept");
        look(20'h00037, 1'b0, "R3 third present");

        // R4 R5: counter-driven victim order across full set 7
        fill(20'h00047, 1'b0, 20'h00400, 1'b1, "R3 fill fourth");
        for (int k = 0; k < 8; k++) begin
            for (int h = 0; h < (k % 3); h++) look(20'h00017 + 20'h00010 * (h % 4), 1'b0, "R4 hit step");
            look(20'h09007 + 20'h00010 * k, 1'b0, "R5 miss");
            fill(20'h09007 + 20'h00010 * k, 1'b0, 20'h50000 + 20'(k), 1'b0, "R5 replace");
            for (int p = 0; p < 4; p++) look(20'h00017 + 20'h00010 * p, 1'b0, "R5 probe");
            look(20'h09007 + 20'h00010 * k, 1'b0, "R5 new present");
        end

        // R7: flush keeps counter; flush with fill drops fill
        do_flush("R7 flush");
        look(20'h00017, 1'b0, "R7 miss after flush");
        cyc(1'b0, '0, 1'b0, 1'b1, 20'h00088, 1'b1, 20'h77777, 1'b0, 1'b1, "R7 flush+fill");
        look(20'h00088, 1'b1, "R7 dropped fill");
        for (int p = 0; p < 4; p++) fill(20'h00108 + 20'h00100 * p, 1'b1, 20'h66600 + 20'(p), 1'b0, "R7 refill");
        look(20'h0F008, 1'b1, "R7 miss keeps counter");
        fill(20'h0F008, 1'b1, 20'h12345, 1'b1, "R7 replace");
        for (int p = 0; p < 4; p++) look(20'h00108 + 20'h00100 * p, 1'b1, "R7 probe");

        // R8: same-cycle fill and lookup of the same page
        cyc(1'b1, 20'h0000A, 1'b0, 1'b1, 20'h0000A, 1'b0, 20'hCAFE0, 1'b1, 1'b0, "R8 same cycle");
        check("R8 old contents", 32'(last_hit), 32'd0);
        look(20'h0000A, 1'b0, "R8 after fill");
        check("R8 new contents", 32'(last_hit), 32'd1);

        // R9: refill of a present page reuses its way
        fill(20'h0001B, 1'b0, 20'h00B01, 1'b0, "R9 fill");
        fill(20'h0001B, 1'b0, 20'h00B02, 1'b1, "R9 refill");
        for (int p = 1; p < 4; p++) fill(20'h0001B + 20'h00010 * p, 1'b0, 20'h00B10 + 20'(p), 1'b0, "R9 fill");
        for (int p = 0; p < 4; p++) look(20'h0001B + 20'h00010 * p, 1'b0, "R9 all four hit");

        // R6: large pages, index vpn[4:1], ppn bit 0 from vpn
        do_flush("R6 flush");
        pg_large = 1'b1;
        fill(20'h00246, 1'b0, 20'h55554, 1'b0, "R6 fill");
        look(20'h00247, 1'b0, "R6 odd half");
        check("R6 ppn bit0", 32'(rsp_ppn), 32'h55555);
        look(20'h00246, 1'b0, "R6 even half");
        check("R6 ppn even", 32'(rsp_ppn), 32'h55554);
        look(20'h00266, 1'b0, "R6 other tag same set");
        fill(20'h00066, 1'b1, 20'h0AAAA, 1'b1, "R6 fill");
        look(20'h00067, 1'b1, "R6 hit wp");
        do_flush("R6 flush");
        pg_large = 1'b0;
        look(20'h00247, 1'b0, "R6 small after flush");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule